// File: doc/BRIEF.md
# Exponential Operand Aligner

This block is the entry stage of a parameterized floating-point exponential unit. It accepts one operand in a flagged floating-point word, turns the significand 1.F into a signed two's-complement fixed-point value scaled by the operand's unbiased exponent, and decides early whether the final result is already known. A known result can be NaN, positive infinity, zero or exactly one. The later stages of the unit consume the fixed-point value. Those stages perform the multiply by the reciprocal of ln 2, the table lookups and the rounding.

The operand word is `{flags[1:0], sign, exp[WE-1:0], frac[WF-1:0]}`. The flags occupy the top two bits, the sign is the next bit down, and the fraction sits at the bottom. The exponent bias is 2^(WE-1)-1. The fixed-point output is WE+WF+G+1 bits wide. Its low WF+G-1 bits are fraction bits, and the remaining WE+2 bits are the integer part, sign included. The shifter is asymmetric. It shifts left by at most WE places and flags anything larger as out of range. It shifts right by whatever the exponent asks, truncating the magnitude.

A single register stage with a valid bit sits between the input and the outputs. There is no back-pressure.

Top module: `exp_align`

## Requirements
- R1: An operand whose flags are 2'b11 produces kind 3 (NaN) whatever its sign, with the fixed-point output 0 and both range flags low.
- R2: An operand whose flags are 2'b10 produces kind 2 (+inf) when the sign is 0 and kind 1 (zero) when the sign is 1, with both range flags low.
- R3: An operand whose flags are 2'b00 produces kind 4 (exactly one) with the fixed-point output 0.
- R4: For flags 2'b01 and an unbiased exponent e in 0..WE, kind is 0 (compute) and the output equals ±(1.F·2^e) with WF+G-1 fraction bits.
- R5: For flags 2'b01 and e < 0, the magnitude 1.F is shifted right by -e and truncated toward zero before the sign is applied, and kind is 0. A shift that leaves no set bit gives the output 0.
- R6: For flags 2'b01 and e > WE, a positive operand raises the overflow flag with kind 2 and a negative operand raises the underflow flag with kind 1. In both cases the fixed-point output is 0.
- R7: Whenever kind is not 0, the fixed-point output is 0, and the overflow and underflow flags are never high together.
- R8: The outputs change one clock after an accepted operand, and out_valid mirrors in_valid one clock later. While in_valid is low, the data outputs hold their values. Reset clears out_valid, the data outputs and the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_word | input | WE+WF+3 | Flagged floating-point operand |
| out_valid | output | 1 | Outputs carry a new result |
| out_xfix | output | WE+WF+G+1 | Signed fixed-point operand |
| out_kind | output | 3 | 0 compute, 1 zero, 2 +inf, 3 NaN, 4 one |
| out_ovf | output | 1 | Exponent too large, positive operand |
| out_unf | output | 1 | Exponent too large, negative operand |

## Verification
The bench builds the block with WE=5, WF=10 and G=5, which gives a bias of 15 and 32 biased exponents. It sweeps every exponent code with both signs and several fractions against a plain integer shift model. At this size the full range is reachable in a few hundred operands. That range includes the widest legal left shift (e=5), the first out-of-range code (e=6), and right shifts deep enough to empty the magnitude entirely. All four flag codes are driven with both signs, and a hold test checks that an idle input leaves the outputs untouched.

// File: rtl/exa_pkg.sv
package exa_pkg;
   typedef enum logic [2:0] {
      K_RUN  = 3'd0,
      K_ZERO = 3'd1,
      K_INF  = 3'd2,
      K_NAN  = 3'd3,
      K_ONE  = 3'd4
   } xkind_t;
endpackage

// File: rtl/exa_classify.sv
module exa_classify #(
   parameter int WE  = 5,
   parameter int LSW = $clog2(WE + 1)
) (
   input  logic [1:0]     flags,
   input  logic           sgn,
   input  logic [WE-1:0]  bexp,
   output logic [2:0]     kind,
   output logic           ovf,
   output logic           unf,
   output logic           go_left,
   output logic [LSW-1:0] lamt,
   output logic [WE-1:0]  ramt
);
   import exa_pkg::*;

   localparam int BIAS = (1 << (WE - 1)) - 1;

   logic signed [WE+1:0] ue;

   always_comb begin
      ue      = $signed({2'b00, bexp}) - $signed((WE+2)'(BIAS));
      go_left = !ue[WE+1];
      lamt    = ue[LSW-1:0];
      ramt    = WE'(BIAS) - bexp;
      kind    = K_RUN;
      ovf     = 1'b0;
      unf     = 1'b0;
      case (flags)
         2'b11: kind = K_NAN;
         2'b10: kind = sgn ? K_ZERO : K_INF;
         2'b00: kind = K_ONE;
         default: begin
            if (ue > $signed((WE+2)'(WE))) begin
               if (sgn) begin
                  unf  = 1'b1;
                  kind = K_ZERO;
               end else begin
                  ovf  = 1'b1;
                  kind = K_INF;
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/exa_barrel.sv
module exa_barrel #(
   parameter int W    = 20,
   parameter int SW   = 3,
   parameter bit LEFT = 1'b1
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [SW:0][W-1:0] stg;

   assign stg[0] = din;

   for (genvar i = 0; i < SW; i++) begin : g_stage
      if (LEFT) begin : g_left
         assign stg[i+1] = amt[i] ? (stg[i] << (1 << i)) : stg[i];
      end else begin : g_right
         assign stg[i+1] = amt[i] ? (stg[i] >> (1 << i)) : stg[i];
      end
   end

   assign dout = stg[SW];
endmodule

// File: rtl/exa_shift.sv
module exa_shift #(
   parameter int WE  = 5,
   parameter int WF  = 10,
   parameter int G   = 5,
   parameter int LSW = $clog2(WE + 1),
   parameter int MW  = WE + WF + G
) (
   input  logic [WF-1:0]  frac,
   input  logic           go_left,
   input  logic [LSW-1:0] lamt,
   input  logic [WE-1:0]  ramt,
   output logic [MW-1:0]  mag
);
   logic [MW-1:0] base;
   logic [MW-1:0] lval;
   logic [MW-1:0] rval;

   // Leading one lands on the unit position (bit WF+G-1).
   assign base = MW'({1'b1, frac}) << (G - 1);

   exa_barrel #(.W(MW), .SW(LSW), .LEFT(1'b1)) u_lsh (
      .din(base), .amt(lamt), .dout(lval));

   exa_barrel #(.W(MW), .SW(WE), .LEFT(1'b0)) u_rsh (
      .din(base), .amt(ramt), .dout(rval));

   assign mag = go_left ? lval : rval;
endmodule

// File: rtl/exp_align.sv
module exp_align #(
   parameter int WE = 5,
   parameter int WF = 10,
   parameter int G  = 5,
   parameter int IW = WE + WF + 3,
   parameter int W  = WE + WF + G + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [IW-1:0] in_word,
   output logic          out_valid,
   output logic [W-1:0]  out_xfix,
   output logic [2:0]    out_kind,
   output logic          out_ovf,
   output logic          out_unf
);
   import exa_pkg::*;

   localparam int LSW = $clog2(WE + 1);
   localparam int MW  = WE + WF + G;

   if (WE < 2) begin : g_bad_we
      $error("exp_align: WE must be at least 2");
   end
   if (WF < 1) begin : g_bad_wf
      $error("exp_align: WF must be at least 1");
   end
   if (G < 1) begin : g_bad_g
      $error("exp_align: G must be at least 1");
   end

   logic [1:0]     flags;
   logic           sgn;
   logic [WE-1:0]  bexp;
   logic [WF-1:0]  frac;
   logic [2:0]     kind;
   logic           ovf, unf, go_left;
   logic [LSW-1:0] lamt;
   logic [WE-1:0]  ramt;
   logic [MW-1:0]  mag;
   logic [W-1:0]   sval;

   assign {flags, sgn, bexp, frac} = in_word;

   exa_classify #(.WE(WE), .LSW(LSW)) u_cls (
      .flags(flags), .sgn(sgn), .bexp(bexp), .kind(kind),
      .ovf(ovf), .unf(unf), .go_left(go_left), .lamt(lamt), .ramt(ramt));

   exa_shift #(.WE(WE), .WF(WF), .G(G), .LSW(LSW), .MW(MW)) u_shf (
      .frac(frac), .go_left(go_left), .lamt(lamt), .ramt(ramt), .mag(mag));

   always_comb begin
      if (kind != K_RUN) sval = '0;
      else if (sgn)      sval = -{1'b0, mag};
      else               sval = {1'b0, mag};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_xfix  <= '0;
         out_kind  <= K_RUN;
         out_ovf   <= 1'b0;
         out_unf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_xfix <= sval;
            out_kind <= kind;
            out_ovf  <= ovf;
            out_unf  <= unf;
         end
      end
   end
endmodule

// File: rtl/exa_chk.sv
module exa_chk #(
   parameter int WE = 5,
   parameter int WF = 10,
   parameter int G  = 5,
   parameter int W  = WE + WF + G + 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [2:0]   in_head,
   input logic         out_valid,
   input logic [W-1:0] out_xfix,
   input logic [2:0]   out_kind,
   input logic         out_ovf,
   input logic         out_unf
);
   assert_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_head[2:1] == 2'b11) |=> (out_kind == 3'd3 && !out_ovf && !out_unf));

   assert_neg_inf_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_head == 3'b101) |=> (out_kind == 3'd1 && !out_unf));

   assert_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_head[2:1] == 2'b00) |=> (out_kind == 3'd4 && out_xfix == '0));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_kind == 3'd2));

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_unf |-> (out_kind == 3'd1));

   assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_kind != 3'd0) |-> (out_xfix == '0));

   assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_ovf && out_unf));

   assert_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_xfix) && $stable(out_kind)));
endmodule

bind exp_align exa_chk #(.WE(WE), .WF(WF), .G(G)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .in_head(in_word[WE+WF+2:WE+WF]),
   .out_valid(out_valid), .out_xfix(out_xfix), .out_kind(out_kind),
   .out_ovf(out_ovf), .out_unf(out_unf));

// File: tb/sim_exp_align.sv
`timescale 1ns/1ps
module sim_exp_align;
   localparam int WE = 5;
   localparam int WF = 10;
   localparam int G  = 5;
   localparam int IW = WE + WF + 3;
   localparam int W  = WE + WF + G + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [IW-1:0] in_word = '0;
   logic          out_valid;
   logic [W-1:0]  out_xfix;
   logic [2:0]    out_kind;
   logic          out_ovf, out_unf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   exp_align #(.WE(WE), .WF(WF), .G(G)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_xfix(out_xfix), .out_kind(out_kind),
      .out_ovf(out_ovf), .out_unf(out_unf));

   task automatic chk(input string req, input logic [W+5:0] act, input logic [W+5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioral model: plain integer shifts.
   task automatic model(input logic [1:0] fl, input logic s, input logic [4:0] e,
                        input logic [9:0] f, output logic [W-1:0] x,
                        output logic [2:0] k, output logic ov, output logic un);
      int ue;
      longint m;
      ue = int'(e) - 15;
      m  = longint'(1024 + int'(f)) << (G - 1);
      x = '0; k = 3'd0; ov = 1'b0; un = 1'b0;
      if (fl == 2'b11) k = 3'd3;
      else if (fl == 2'b10) k = s ? 3'd1 : 3'd2;
      else if (fl == 2'b00) k = 3'd4;
      else if (ue > WE) begin
         if (s) begin un = 1'b1; k = 3'd1; end
         else   begin ov = 1'b1; k = 3'd2; end
      end else begin
         if (ue >= 0) m = m << ue;
         else         m = m >> (-ue);
         m = m & ((longint'(1) << (W - 1)) - 1);
         if (s) m = -m;
         x = W'(m);
      end
   endtask

   task automatic send(input logic [1:0] fl, input logic s, input logic [4:0] e,
                       input logic [9:0] f);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = {fl, s, e, f};
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_check(input string req, input logic [1:0] fl, input logic s,
                             input logic [4:0] e, input logic [9:0] f);
      logic [W-1:0] x;
      logic [2:0] k;
      logic ov, un;
      model(fl, s, e, f, x, k, ov, un);
      send(fl, s, e, f);
      chk(req, {out_valid, out_kind, out_ovf, out_unf, out_xfix},
               {1'b1, k, ov, un, x});
   endtask

   task automatic t_reset;
      chk("R8 reset", {out_valid, out_kind, out_ovf, out_unf, out_xfix}, '0);
   endtask

   task automatic t_flags;
      send_check("R1 nan pos", 2'b11, 1'b0, 5'd20, 10'h155);
      send_check("R1 nan neg", 2'b11, 1'b1, 5'd3, 10'h0);
      send_check("R2 +inf", 2'b10, 1'b0, 5'd0, 10'h0);
      send_check("R2 -inf", 2'b10, 1'b1, 5'd31, 10'h3FF);
      send_check("R3 zero pos", 2'b00, 1'b0, 5'd0, 10'h0);
      send_check("R3 zero neg", 2'b00, 1'b1, 5'd9, 10'h2A5);
   endtask

   task automatic t_fixed;
      send(2'b01, 1'b0, 5'd15, 10'h0);
      chk("R4 one", {1'b0, out_kind, out_xfix}, {1'b0, 3'd0, 21'h04000});
      send(2'b01, 1'b0, 5'd14, 10'h0);
      chk("R5 half", {1'b0, out_kind, out_xfix}, {1'b0, 3'd0, 21'h02000});
      send(2'b01, 1'b0, 5'd20, 10'h3FF);
      chk("R4 max left", {1'b0, out_kind, out_xfix}, {1'b0, 3'd0, 21'h0FFE00});
      send(2'b01, 1'b1, 5'd20, 10'h3FF);
      chk("R4 max left neg", {1'b0, out_kind, out_xfix}, {1'b0, 3'd0, 21'h100200});
      send(2'b01, 1'b0, 5'd21, 10'h0);
      chk("R6 ovf", {out_ovf, out_unf, out_kind, out_xfix}, {1'b1, 1'b0, 3'd2, 21'h0});
      send(2'b01, 1'b1, 5'd21, 10'h0);
      chk("R6 unf", {out_ovf, out_unf, out_kind, out_xfix}, {1'b0, 1'b1, 3'd1, 21'h0});
      send(2'b01, 1'b1, 5'd0, 10'h3FF);
      chk("R5 drained", {out_kind, out_xfix}, {3'd0, 21'h0});
   endtask

   task automatic t_sweep;
      logic [9:0] fr [3] = '{10'h000, 10'h3FF, 10'h2A5};
      for (int e = 0; e < 32; e++) begin
         for (int s = 0; s < 2; s++) begin
            for (int j = 0; j < 3; j++) begin
               if (e - 15 > WE)     send_check("R6 sweep", 2'b01, s[0], e[4:0], fr[j]);
               else if (e >= 15)    send_check("R4 sweep", 2'b01, s[0], e[4:0], fr[j]);
               else                 send_check("R5 sweep", 2'b01, s[0], e[4:0], fr[j]);
               if (out_ovf && out_unf) chk("R7 excl", 1, 0);
            end
         end
      end
   endtask

   task automatic t_hold;
      logic [W-1:0] last;
      send(2'b01, 1'b1, 5'd17, 10'h123);
      last = out_xfix;
      @(negedge clk);
      in_word = {2'b11, 1'b0, 5'd2, 10'h3FF};
      @(negedge clk);
      @(negedge clk);
      chk("R8 idle valid", {20'h0, out_valid}, '0);
      chk("R8 idle hold", {out_kind, out_xfix}, {3'd0, last});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_flags();
      t_fixed();
      t_sweep();
      t_hold();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule